// File: doc/BRIEF.md
# Serial Peripheral Interrupt Controller

This block keeps the interrupt bookkeeping for a serial port with four interrupt sources. The transmit and receive paths, which live outside it, report events as single-cycle pulses on one line per source. The block latches each pulse into a sticky state bit and gates that bit with a matching enable bit. It drives the result onto one level-sensitive interrupt line per source.

Software reaches the block through a small word-addressed register port with three locations. Writing the state location with a 1 in a bit position clears that bit. Writing the enable location replaces the whole enable mask. Writing the test location forces bits of the state on, so interrupt handlers can be tested without real traffic. The interrupt lines are registered. Each line updates on the same clock edge that captures the write or event causing the change.

Top module: `uart_irq_ctrl`

## Requirements
- R1: There are four sources, with a fixed bit position each in every register, in `evt_i` and in `irq_o`: bit 0 is transmit watermark, bit 1 is receive watermark, bit 2 is transmit empty, bit 3 is receive overflow.
- R2: `irq_o[i]` is 1 exactly when state bit i and enable bit i are both 1. The line updates on the clock edge that captures the write or event, and not earlier.
- R3: A write to byte offset 0x0 clears each state bit written as 1 and leaves each state bit written as 0 unchanged.
- R4: A write to byte offset 0x8 ORs the written value into the state.
- R5: A read of offset 0x8, or of any offset other than 0x0, 0x4 and 0x8, returns zero. A write to such an unmapped offset changes neither state nor enable.
- R6: A write to offset 0x4 replaces the enable mask completely. Reading 0x4 returns the mask, and reading 0x0 returns the state.
- R7: While `rst_n` is low at a clock edge, state, enable and all interrupt lines become zero.
- R8: A one-cycle pulse on `evt_i[i]` sets state bit i. The bit stays set after the pulse ends, until software clears it.
- R9: When an event pulse and a clearing write to the same bit fall in the same cycle, the bit ends up set.
- R10: Write data bits at position 4 and above are ignored, and read data bits at position 4 and above are always zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 10 | Byte address of the register access |
| reg_wr | input | 1 | Write strobe, one access per cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational from the registers |
| evt_i | input | 4 | Per-source event pulses from the serial paths |
| irq_o | output | 4 | Level interrupt lines, one per source |

## Verification
Writes and events are presented after a falling edge and captured by the next rising edge. The new state, enable and interrupt levels are due right after that rising edge. The bench samples them at the following falling edge. Read data is combinational from the registers, so the bench samples it a nanosecond after the address is set. One case samples `irq_o` between the presentation of a write and its capturing edge, to confirm the line has not moved yet.

// File: rtl/uart_irq_pkg.sv
// Package: uart_irq_pkg
// Shared sizes, register offsets and source numbering for the serial port
// interrupt controller. Assumes byte addressing with word-aligned registers.
package uart_irq_pkg;

    parameter int NUM_SRC = 4;
    parameter int ADDR_W  = 10;
    parameter int DATA_W  = 32;

    // Byte offsets of the register locations
    localparam logic [ADDR_W-1:0] OFS_STATE  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFS_ENABLE = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] OFS_TEST   = ADDR_W'(8);

    // Bit position of each source
    typedef enum int {
        SRC_TX_WMARK = 0,
        SRC_RX_WMARK = 1,
        SRC_TX_EMPTY = 2,
        SRC_RX_OVF   = 3
    } irq_src_e;

    // Decoded write actions for one cycle
    typedef struct packed {
        logic clr_state;
        logic set_state;
        logic load_enable;
    } reg_wr_t;

endpackage

// File: rtl/uart_irq_decode.sv
// Module: uart_irq_decode
// Decodes the register port into per-register write actions and builds the
// read data. Assumes one access per cycle and full address compare.
module uart_irq_decode
    import uart_irq_pkg::*;
#(
    parameter int N  = NUM_SRC,
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic [AW-1:0] reg_addr,
    input  logic          reg_wr,
    input  logic [N-1:0]  state_q,
    input  logic [N-1:0]  en_q,
    output reg_wr_t       wr_act,
    output logic [DW-1:0] reg_rdata
);

    localparam logic [AW-1:0] A_STATE  = AW'(OFS_STATE);
    localparam logic [AW-1:0] A_ENABLE = AW'(OFS_ENABLE);
    localparam logic [AW-1:0] A_TEST   = AW'(OFS_TEST);

    // Write decode: one action at most per cycle
    always_comb begin
        wr_act             = '0;
        wr_act.clr_state   = reg_wr && (reg_addr == A_STATE);
        wr_act.load_enable = reg_wr && (reg_addr == A_ENABLE);
        wr_act.set_state   = reg_wr && (reg_addr == A_TEST);
    end

    // Read mux: test and unmapped locations read as zero
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_STATE) begin
            reg_rdata[N-1:0] = state_q;
        end else if (reg_addr == A_ENABLE) begin
            reg_rdata[N-1:0] = en_q;
        end
    end

endmodule

// File: rtl/uart_irq_bank.sv
// Module: uart_irq_bank
// Holds the sticky state bits and the enable mask. It exposes both the
// registered and the next values, so the output gate can register the
// same edge. Assumes event pulses are synchronous to clk.
module uart_irq_bank
    import uart_irq_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  reg_wr_t      wr_act,
    input  logic [N-1:0] wbits,
    input  logic [N-1:0] evt_i,
    output logic [N-1:0] state_q,
    output logic [N-1:0] state_d,
    output logic [N-1:0] en_q,
    output logic [N-1:0] en_d
);

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_bit
            // Next value of one sticky bit: an event overrides a clear
            always_comb begin
                state_d[g] = state_q[g];
                if (wr_act.clr_state && wbits[g]) state_d[g] = 1'b0;
                if (wr_act.set_state && wbits[g]) state_d[g] = 1'b1;
                if (evt_i[g])                     state_d[g] = 1'b1;
            end

            // Sticky bit storage
            always_ff @(posedge clk) begin
                if (!rst_n) state_q[g] <= 1'b0;
                else        state_q[g] <= state_d[g];
            end
        end
    endgenerate

    // Next enable mask: whole-mask replacement on write
    always_comb begin
        en_d = wr_act.load_enable ? wbits : en_q;
    end

    // Enable mask storage
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

endmodule

// File: rtl/uart_irq_gate.sv
// Module: uart_irq_gate
// Registers the AND of state and enable onto the interrupt lines. It takes
// the next values, so each line moves on the edge that captures its cause.
module uart_irq_gate
    import uart_irq_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] state_d,
    input  logic [N-1:0] en_d,
    output logic [N-1:0] irq_o
);

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_line
            // One registered interrupt line
            always_ff @(posedge clk) begin
                if (!rst_n) irq_o[g] <= 1'b0;
                else        irq_o[g] <= state_d[g] & en_d[g];
            end
        end
    endgenerate

endmodule

// File: rtl/uart_irq_ctrl.sv
// Module: uart_irq_ctrl
// Top level of the serial port interrupt controller: register decode,
// state and enable bank, and registered output gating. Assumes a
// single-cycle register port without wait states.
module uart_irq_ctrl
    import uart_irq_pkg::*;
#(
    parameter int N  = NUM_SRC,
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] reg_addr,
    input  logic          reg_wr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic [N-1:0]  evt_i,
    output logic [N-1:0]  irq_o
);

    reg_wr_t      wr_act;
    logic [N-1:0] state_q;
    logic [N-1:0] state_d;
    logic [N-1:0] en_q;
    logic [N-1:0] en_d;
    logic [N-1:0] wbits;
    logic         unused_wdata_hi;

    // Only the low source bits of write data are meaningful
    assign wbits           = reg_wdata[N-1:0];
    assign unused_wdata_hi = ^reg_wdata[DW-1:N];

    uart_irq_decode #(.N(N), .AW(AW), .DW(DW)) u_dec (
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .state_q   (state_q),
        .en_q      (en_q),
        .wr_act    (wr_act),
        .reg_rdata (reg_rdata)
    );

    uart_irq_bank #(.N(N)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_act  (wr_act),
        .wbits   (wbits),
        .evt_i   (evt_i),
        .state_q (state_q),
        .state_d (state_d),
        .en_q    (en_q),
        .en_d    (en_d)
    );

    uart_irq_gate #(.N(N)) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .state_d (state_d),
        .en_d    (en_d),
        .irq_o   (irq_o)
    );

endmodule

// Module: uart_irq_checker
// Temporal checks on the interrupt controller, attached by bind below.
module uart_irq_checker #(
    parameter int N  = 4,
    parameter int AW = 10,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] reg_addr,
    input logic          reg_wr,
    input logic [DW-1:0] reg_wdata,
    input logic [DW-1:0] reg_rdata,
    input logic [N-1:0]  evt_i,
    input logic [N-1:0]  irq_o,
    input logic [N-1:0]  state_q,
    input logic [N-1:0]  en_q
);

    // R2: registered lines track the registered state and enable
    assert_irq_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (state_q & en_q));

    // R3: bits written as 1 to the state location are clear unless an event hit them
    assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == AW'(0)) |=>
        ((state_q & $past(reg_wdata[N-1:0] & ~evt_i)) == '0));

    // R4: bits written to the test location are set afterwards
    assert_test_or_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == AW'(8)) |=>
        ((state_q & $past(reg_wdata[N-1:0])) == $past(reg_wdata[N-1:0])));

    // R5: test location reads zero
    assert_test_reads_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == AW'(8)) |-> (reg_rdata == '0));

    // R6: enable write replaces the mask
    assert_enable_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == AW'(4)) |=> (en_q == $past(reg_wdata[N-1:0])));

    // R7: reset clears everything
    assert_reset_zero_R7: assert property (@(posedge clk)
        (!rst_n) |=> (state_q == '0 && en_q == '0 && irq_o == '0));

    // R8: no write and no event keeps the state
    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr && evt_i == '0) |=> $stable(state_q));

    // R9: an event always leaves its bit set, even against a clear
    assert_event_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((state_q & $past(evt_i)) == $past(evt_i)));

    // R10: upper read data bits stay zero
    assert_rdata_hi_R10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[DW-1:N] == '0);

endmodule

bind uart_irq_ctrl uart_irq_checker #(.N(N), .AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .evt_i     (evt_i),
    .irq_o     (irq_o),
    .state_q   (state_q),
    .en_q      (en_q)
);

// File: tb/sim_uart_irq_ctrl.sv
`timescale 1ns/1ps
// Bench: sweeps all state, enable, clear, test and event patterns of the
// four-source controller and compares against arithmetic expectations.
module sim_uart_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  evt_i = '0;
    logic [3:0]  irq_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    uart_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_i(evt_i),
        .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle with optional write and events; ends at a falling edge
    task automatic cycle(input logic wr, input logic [9:0] a, input logic [31:0] d, input logic [3:0] e);
        @(negedge clk);
        reg_wr = wr; reg_addr = a; reg_wdata = d; evt_i = e;
        @(negedge clk);
        reg_wr = 1'b0; evt_i = '0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] v);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic load(input logic [3:0] s, input logic [3:0] en);
        cycle(1'b1, 10'h0, 32'hF, 4'h0);
        cycle(1'b1, 10'h8, {28'h0, s}, 4'h0);
        cycle(1'b1, 10'h4, {28'h0, en}, 4'h0);
    endtask

    initial begin : watchdog
        #(200000 * 4);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        // R7: reset with activity on the inputs
        @(negedge clk); reg_wr = 1'b1; reg_addr = 10'h8; reg_wdata = 32'hF; evt_i = 4'hF;
        repeat (3) @(negedge clk);
        reg_wr = 1'b0; evt_i = '0; reg_wdata = '0;
        check("R7 irq", {28'h0, irq_o}, 32'h0);
        rd(10'h0, v); check("R7 state", v, 32'h0);
        rd(10'h4, v); check("R7 enable", v, 32'h0);
        @(negedge clk); rst_n = 1'b1;

        // R8, R1: each source's pulse sets only its own bit and it sticks
        for (int i = 0; i < 4; i++) begin
            load(4'h0, 4'hF);
            cycle(1'b0, 10'h0, 32'h0, 4'(1 << i));
            check("R1 irq line", {28'h0, irq_o}, 32'(1 << i));
            repeat (3) @(negedge clk);
            rd(10'h0, v); check("R8 sticky", v, 32'(1 << i));
        end

        // R2 timing: line unchanged before the capturing edge
        load(4'h0, 4'hF);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 10'h8; reg_wdata = 32'h5;
        #1 check("R2 before edge", {28'h0, irq_o}, 32'h0);
        @(negedge clk); reg_wr = 1'b0;
        check("R2 after edge", {28'h0, irq_o}, 32'h5);

        // R2, R6: all state x enable patterns
        for (int s = 0; s < 16; s++) begin
            for (int en = 0; en < 16; en++) begin
                load(4'(s), 4'(en));
                check("R2 gate", {28'h0, irq_o}, 32'(s & en));
                rd(10'h0, v); check("R6 state read", v, 32'(s));
                rd(10'h4, v); check("R6 enable read", v, 32'(en));
            end
        end

        // R3: write-one-to-clear over all start and clear patterns
        for (int s = 0; s < 16; s++) begin
            for (int c = 0; c < 16; c++) begin
                load(4'(s), 4'hF);
                cycle(1'b1, 10'h0, 32'(c), 4'h0);
                rd(10'h0, v); check("R3 clear", v, 32'(s & ~c & 15));
                check("R3 irq", {28'h0, irq_o}, 32'(s & ~c & 15));
            end
        end

        // R4, R5: test write ORs; test location reads zero
        for (int s = 0; s < 16; s++) begin
            for (int t = 0; t < 16; t++) begin
                load(4'(s), 4'h0);
                cycle(1'b1, 10'h8, 32'(t), 4'h0);
                rd(10'h0, v); check("R4 or", v, 32'(s | t));
                rd(10'h8, v); check("R5 test read", v, 32'h0);
            end
        end

        // R9: event against a clear in the same cycle
        for (int c = 0; c < 16; c++) begin
            for (int e = 0; e < 16; e++) begin
                load(4'hF, 4'hF);
                cycle(1'b1, 10'h0, 32'(c), 4'(e));
                rd(10'h0, v); check("R9 event wins", v, 32'((15 & ~c) | e));
            end
        end

        // R10: upper write bits ignored, upper read bits zero
        load(4'h0, 4'h0);
        cycle(1'b1, 10'h4, 32'hFFFF_FFF6, 4'h0);
        rd(10'h4, v); check("R10 enable", v, 32'h6);
        cycle(1'b1, 10'h8, 32'hFFFF_FFF0, 4'h0);
        rd(10'h0, v); check("R10 test hi", v, 32'h0);
        cycle(1'b1, 10'h8, 32'hFFFF_FFF9, 4'h0);
        rd(10'h0, v); check("R10 state", v, 32'h9);

        // R5: unmapped offsets read zero and writes there change nothing
        load(4'hA, 4'h5);
        for (int a = 12; a < 1024; a += 52) begin
            cycle(1'b1, 10'(a), 32'hFFFF_FFFF, 4'h0);
            rd(10'(a), v); check("R5 unmapped read", v, 32'h0);
        end
        rd(10'h0, v); check("R5 state kept", v, 32'hA);
        rd(10'h4, v); check("R5 enable kept", v, 32'h5);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule